// File: doc/BRIEF.md
# Overload Fault Timer Latch

This block supervises a switching converter for sustained overload or short circuit, purely on digital flags. A comparator elsewhere raises a fault flag while the sensed switch current is above its limit. Each clock cycle in which the flag is high adds one unit to an accumulated fault time. When that time reaches a programmed delay, the block latches a permanent shutdown. The pulse generator uses this signal to stop driving the power switch.

The accumulated time is not cleared by a brief break in the fault. A per-switching-period strobe marks period boundaries, and a 2-bit counter tracks how many consecutive periods passed with no fault. Only the third such period clears the accumulated time. A shorter gap leaves the accumulated time in place, so an intermittent overload still reaches the shutdown. The latched shutdown is released only by a brown-out reset or by an undervoltage reset. Both reset inputs are synchronous and take precedence over counting.

The delay is CYC_PER_MS clock cycles times a millisecond count. That count is SHORT_MS (15) by default, or LONG_MS (150) when EXTENDED is set.

Top module: `ovl_fault_timer`

## Requirements
- R1: After rst_ni is released, latched_o and running_o are both 0.
- R2: While not latched, each rising clock edge with fault_i=1 adds one cycle to the accumulated fault time. running_o is 1 whenever the accumulated time is nonzero and the block is not latched.
- R3: latched_o becomes 1 at the edge that counts the LIMIT-th accumulated fault cycle, where LIMIT = CYC_PER_MS * (EXTENDED ? LONG_MS : SHORT_MS). Once set, it stays 1 under any fault_i or period_i activity until a reset input is applied, and running_o is 0 while latched.
- R4: A period ends at an edge where period_i=1. The period is faulty if fault_i was 1 in any cycle after the previous strobe, up to and including the strobe cycle itself. The edge that ends the third consecutive fault-free period clears the accumulated time, so running_o falls.
- R5: A run of zero, one or two consecutive fault-free periods neither clears nor advances the accumulated time. Fault cycles that follow add to the time already held.
- R6: bo_rst_i=1 at an edge clears latched_o, the accumulated time and the fault-free period count, even if fault_i=1 in the same cycle.
- R7: uv_rst_i=1 at an edge has the same clearing effect as bo_rst_i.
- R8: With EXTENDED=1 the latch needs LONG_MS/SHORT_MS times as many fault cycles as with EXTENDED=0 (150 against 15 milliseconds' worth).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 1 | One-cycle strobe marking the end of each switching period |
| fault_i | input | 1 | Current-limit fault flag, sampled every cycle |
| bo_rst_i | input | 1 | Brown-out reset, synchronous, active high |
| uv_rst_i | input | 1 | Undervoltage reset, synchronous, active high |
| latched_o | output | 1 | Permanent shutdown request |
| running_o | output | 1 | Accumulated fault time is nonzero and the block is not latched |

## Verification
The assertions assume that fault_i, period_i and the reset inputs are synchronous single-bit levels. They also assume that a rise of running_o or latched_o can only follow a sampled fault, and that a fall of running_o can only follow a period strobe or a reset.

The stimulus changes inputs only on the falling clock edge and keeps period_i as a one-cycle strobe. The delay is scaled down (two cycles per millisecond), so the latch point is reached within hundreds of cycles. The bench sweeps fault-burst lengths against fault-free gaps of zero to four periods. For each pair it computes the expected cycles to shutdown from LIMIT.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef logic [1:0] clean_cnt_t;
  localparam clean_cnt_t CLEAN_NEEDED = 2'd3;

  function automatic int unsigned delay_cycles(input int unsigned cyc_per_ms,
                                               input int unsigned ms);
    return cyc_per_ms * ms;
  endfunction
endpackage

// File: rtl/ovl_period_tracker.sv
module ovl_period_tracker
  import ovl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic period_i,
  input  logic fault_i,
  output logic clear_o
);
  logic       per_fault_q;
  clean_cnt_t clean_q;
  logic       dirty;

  assign dirty   = per_fault_q | fault_i;
  assign clear_o = en_i && period_i && !dirty && (clean_q == CLEAN_NEEDED - 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_fault_q <= 1'b0;
      clean_q     <= '0;
    end else if (clr_i) begin
      per_fault_q <= 1'b0;
      clean_q     <= '0;
    end else if (en_i) begin
      if (period_i) begin
        per_fault_q <= 1'b0;
        if (dirty)                       clean_q <= '0;
        else if (clean_q != CLEAN_NEEDED) clean_q <= clean_q + 2'd1;
      end else if (fault_i) begin
        per_fault_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_delay_counter.sv
module ovl_delay_counter #(
  parameter int unsigned LIMIT = 30,
  localparam int unsigned W    = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic inc_i,
  input  logic zero_i,
  output logic expire_o,
  output logic busy_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = en_i && inc_i && (cnt_q == W'(LIMIT - 1));
  assign busy_o   = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i) begin
      if (inc_i)            cnt_q <= cnt_q + W'(1);
      else if (zero_i)      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/ovl_fault_latch.sv
module ovl_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic latched_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latched_o <= 1'b0;
    else if (clr_i)  latched_o <= 1'b0;
    else if (set_i)  latched_o <= 1'b1;
  end
endmodule

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer
  import ovl_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 100000,
  parameter int unsigned SHORT_MS   = 15,
  parameter int unsigned LONG_MS    = 150,
  parameter bit          EXTENDED   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic period_i,
  input  logic fault_i,
  input  logic bo_rst_i,
  input  logic uv_rst_i,
  output logic latched_o,
  output logic running_o
);
  localparam int unsigned LIMIT =
    delay_cycles(CYC_PER_MS, EXTENDED ? LONG_MS : SHORT_MS);

  logic clr, en, clear_acc, expire, busy;

  assign clr = bo_rst_i | uv_rst_i;
  assign en  = ~latched_o;

  ovl_period_tracker u_period (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .en_i    (en),
    .period_i(period_i),
    .fault_i (fault_i),
    .clear_o (clear_acc)
  );

  ovl_delay_counter #(.LIMIT(LIMIT)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .en_i    (en),
    .inc_i   (fault_i),
    .zero_i  (clear_acc),
    .expire_o(expire),
    .busy_o  (busy)
  );

  ovl_fault_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .set_i    (expire),
    .latched_o(latched_o)
  );

  assign running_o = busy & ~latched_o;
endmodule

// File: rtl/ovl_fault_timer_chk.sv
module ovl_fault_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic period_i,
  input logic fault_i,
  input logic bo_rst_i,
  input logic uv_rst_i,
  input logic latched_o,
  input logic running_o
);
  // R3: shutdown holds until a reset input
  a_r3_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o && !bo_rst_i && !uv_rst_i |=> latched_o);

  // R3: shutdown only arises from a counted fault cycle
  a_r3_latch_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> $past(fault_i));

  // R2: accumulation starts only on a fault cycle
  a_r2_run_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> $past(fault_i));

  // R4: accumulated time drops only at a strobe, a reset or the latch
  a_r4_clear_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) && !latched_o |-> $past(period_i) || $past(bo_rst_i) || $past(uv_rst_i));

  // R6, R7: reset inputs win over counting
  a_r6_r7_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_rst_i || uv_rst_i |=> !latched_o && !running_o);
endmodule

bind ovl_fault_timer ovl_fault_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .period_i (period_i),
  .fault_i  (fault_i),
  .bo_rst_i (bo_rst_i),
  .uv_rst_i (uv_rst_i),
  .latched_o(latched_o),
  .running_o(running_o)
);

// File: tb/tb_ovl_fault_timer.sv
module tb_ovl_fault_timer;
  localparam int CPM   = 2;
  localparam int LIM   = CPM * 15;
  localparam int LIM_X = CPM * 150;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic period = 0, fault = 0, bo = 0, uv = 0;
  logic lat, run, lat_x, run_x;
  int   errors = 0, checks = 0;

  always #5 clk = ~clk;

  ovl_fault_timer #(.CYC_PER_MS(CPM), .EXTENDED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(period), .fault_i(fault),
    .bo_rst_i(bo), .uv_rst_i(uv), .latched_o(lat), .running_o(run));

  ovl_fault_timer #(.CYC_PER_MS(CPM), .EXTENDED(1'b1)) dut_ext (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(period), .fault_i(fault),
    .bo_rst_i(bo), .uv_rst_i(uv), .latched_o(lat_x), .running_o(run_x));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic f, input logic s, input logic b, input logic u);
    fault = f; period = s; bo = b; uv = u;
    @(posedge clk);
    @(negedge clk);
    fault = 0; period = 0; bo = 0; uv = 0;
  endtask

  task automatic clean_periods(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) tick(0, 0, 0, 0);
      tick(0, 1, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bursts[3];
    int n, exp_n, n_std;
    bursts[0] = 1; bursts[1] = 5; bursts[2] = LIM - 1;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(lat == 0 && run == 0 && lat_x == 0, "R1 reset state", {lat, run}, 0);

    // R4: fault only on a strobe cycle still dirties that period
    tick(1, 1, 0, 0);
    chk(run == 1, "R2 single fault cycle arms", run, 1);
    clean_periods(2);
    chk(run == 1, "R5 two clean periods keep time", run, 1);
    clean_periods(1);
    chk(run == 0, "R4 third clean period clears", run, 0);

    // R3/R4/R5 sweep: burst length against gap length
    foreach (bursts[bi]) begin
      for (int g = 0; g <= 4; g++) begin
        tick(0, 0, 1, 0);
        repeat (bursts[bi]) tick(1, 0, 0, 0);
        chk(run == 1, "R2 burst accumulates", run, 1);
        tick(0, 1, 0, 0);
        clean_periods(g);
        chk(run == int'(g < 3), $sformatf("R4 R5 running after gap %0d", g), run, int'(g < 3));
        exp_n = (g < 3) ? LIM - bursts[bi] : LIM;
        n = 0;
        do begin tick(1, 0, 0, 0); n++; end while (!lat && n < LIM + 4);
        chk(n == exp_n && run == 0,
            $sformatf("R3 R5 cycles to latch burst %0d gap %0d", bursts[bi], g), n, exp_n);
      end
    end

    // R3 permanence
    clean_periods(5);
    tick(1, 1, 0, 0);
    chk(lat == 1 && run == 0, "R3 latch holds", lat, 1);

    // R6 brown-out reset beats a concurrent fault
    tick(1, 0, 1, 0);
    chk(lat == 0 && run == 0, "R6 bo reset clears", {lat, run}, 0);

    // R7 undervoltage reset
    repeat (LIM) tick(1, 0, 0, 0);
    chk(lat == 1, "R7 relatched before uv", lat, 1);
    tick(0, 0, 0, 1);
    chk(lat == 0 && run == 0, "R7 uv reset clears", {lat, run}, 0);

    // R7: uv also clears partial time and the clean count
    repeat (4) tick(1, 0, 0, 0);
    tick(0, 0, 0, 1);
    chk(run == 0, "R7 uv clears partial time", run, 0);

    // R8 extended delay
    tick(0, 0, 1, 0);
    n = 0; n_std = 0;
    do begin
      tick(1, 0, 0, 0); n++;
      if (lat && n_std == 0) n_std = n;
    end while (!lat_x && n < LIM_X + 4);
    chk(n_std == LIM, "R8 standard delay", n_std, LIM);
    chk(n == LIM_X, "R8 extended delay", n, LIM_X);
    chk(n == n_std * 10, "R8 ratio", n, n_std * 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule